// File: doc/BRIEF.md
# Indirect Effective Address Generator

This block works out the 15-bit word address that a 16-bit memory-reference instruction points at. It takes the instruction word, the program counter value that follows the instruction, and two 16-bit accumulators that can serve as base registers. From these it forms a base-plus-displacement address. When the instruction asks for indirection, it then follows a chain of pointer words through a request/acknowledge word-memory port until it reaches a pointer whose top bit is clear.

Sixteen low memory locations update themselves when they are used as pointers. Eight of them add one and eight subtract one, and the new value is written back before it is used. The decision whether the chain goes on is taken from the top bit of the word as it was read, before that update. Because a chain can be arbitrarily long, the block counts pointer reads against a limit that can be set. When the count reaches the limit, the walk stops with an error pulse and no address.

A controller pulses `start` with the instruction fields valid. It then waits for a one-cycle `done` pulse, with `ea` valid in that cycle, or for a one-cycle `err` pulse.

Top module: `ea_indirect_gen`

## Requirements
- R1: While reset is active and after it is released, `done`, `err` and `mem_req` are low. The depth limit comes out of reset at 16.
- R2: The instruction fields are: indirect flag in `instr[10]`, base select in `instr[9:8]`, displacement in `instr[7:0]`. Base select 0 gives the displacement zero-extended as the address.
- R3: Base select 1 adds the sign-extended displacement to `pc_next - 1`, which is the address of the instruction itself. The sum wraps modulo 2^15.
- R4: Base selects 2 and 3 add the sign-extended displacement to the low 15 bits of `acc2` or `acc3` respectively. The sum wraps modulo 2^15.
- R5: A direct instruction (`instr[10]`=0) raises `done` in the cycle after the `start` edge, with `ea` valid. It makes no memory access. `done` never stays high for two cycles in a row.
- R6: An indirect instruction reads the word at the computed address. The low 15 bits of that word become the next address. If the word's bit 15 is set, another read follows at that address; otherwise that address is the result.
- R7: A pointer read from addresses 16..23 is incremented modulo 2^16 and written back to the same address before use. Its low 15 bits after the update form the next address. Only addresses 16..31 are ever written.
- R8: A pointer read from addresses 24..31 is decremented modulo 2^16, written back and used in the same way.
- R9: Whether the chain continues depends on bit 15 of the pointer as read, never on the updated value.
- R10: The number of pointer reads in a walk is counted. When the count reaches the depth limit, the walk ends with a one-cycle `err` pulse and no `done`, even if that last pointer had bit 15 clear. A chain that needs k reads therefore completes only if k is less than the limit. Pulsing `lim_wr` loads `lim_val` as the new limit.
- R11: `start` is ignored while a walk is in progress.
- R12: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`. A read's data is taken in the acknowledged cycle. `done` or `err` rises in the cycle after the final acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address computation |
| instr | input | 16 | Instruction word |
| pc_next | input | 15 | Program counter following the instruction |
| acc2 | input | 16 | First base accumulator |
| acc3 | input | 16 | Second base accumulator |
| lim_wr | input | 1 | Load a new depth limit |
| lim_val | input | 8 | Depth limit value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 16 | Memory read data, valid with ack |
| done | output | 1 | Address valid pulse |
| err | output | 1 | Depth limit reached pulse |
| ea | output | 15 | Effective address |

## Verification
A direct computation is due at the first falling edge after the `start` edge, and the bench expects `done` exactly there. For an indirect computation, the bench memory model records the cycle in which it gives its last acknowledge. The result is then required on the very next cycle, and it is checked against a bench model of the walk, including its write-backs and its read count. The bench samples on the falling edge and looks one cycle later as well, to confirm the pulse dropped. It compares memory and read counts only after the memory model has committed the final write.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_READ  = 2'd1,
    WALK_WRITE = 2'd2
  } walk_state_e;

  typedef enum logic [1:0] {
    BASE_ZERO = 2'd0,
    BASE_PC   = 2'd1,
    BASE_R2   = 2'd2,
    BASE_R3   = 2'd3
  } base_sel_e;

endpackage

// File: rtl/ea_base_calc.sv
module ea_base_calc
  import eagen_pkg::*;
#(
  parameter int AW     = 15,
  parameter int DW     = 16,
  parameter int DISP_W = 8
) (
  input  logic [DW-1:0] instr,
  input  logic [AW-1:0] pc_next,
  input  logic [DW-1:0] reg2,
  input  logic [DW-1:0] reg3,
  output logic [AW-1:0] addr,
  output logic          indirect
);

  localparam int SEL_LO  = DISP_W;
  localparam int IND_BIT = DISP_W + 2;
  localparam int EXT_W   = AW - DISP_W;

  logic [DISP_W-1:0] disp;
  logic [AW-1:0]     disp_zx;
  logic [AW-1:0]     disp_sx;
  logic [AW-1:0]     pc_self;
  base_sel_e         sel;

  logic unused_bits;
  assign unused_bits = ^{instr[DW-1:IND_BIT+1], reg2[DW-1:AW], reg3[DW-1:AW]};

  assign disp     = instr[DISP_W-1:0];
  assign sel      = base_sel_e'(instr[SEL_LO+1:SEL_LO]);
  assign indirect = instr[IND_BIT];
  assign disp_zx  = {{EXT_W{1'b0}}, disp};
  assign disp_sx  = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign pc_self  = pc_next - {{(AW-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (sel)
      BASE_ZERO: addr = disp_zx;
      BASE_PC:   addr = pc_self + disp_sx;
      BASE_R2:   addr = reg2[AW-1:0] + disp_sx;
      default:   addr = reg3[AW-1:0] + disp_sx;
    endcase
  end

endmodule

// File: rtl/ea_ptr_update.sv
module ea_ptr_update #(
  parameter int AW     = 15,
  parameter int DW     = 16,
  parameter int INC_LO = 16,
  parameter int DEC_LO = 24,
  parameter int SPAN   = 8
) (
  input  logic [AW-1:0] loc,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] upd_word,
  output logic          needs_wb
);

  localparam logic [AW-1:0] INC_FIRST = AW'(INC_LO);
  localparam logic [AW-1:0] INC_LAST  = AW'(INC_LO + SPAN - 1);
  localparam logic [AW-1:0] DEC_FIRST = AW'(DEC_LO);
  localparam logic [AW-1:0] DEC_LAST  = AW'(DEC_LO + SPAN - 1);
  localparam logic [DW-1:0] ONE       = {{(DW-1){1'b0}}, 1'b1};

  logic in_inc;
  logic in_dec;

  assign in_inc   = (loc >= INC_FIRST) && (loc <= INC_LAST);
  assign in_dec   = (loc >= DEC_FIRST) && (loc <= DEC_LAST);
  assign needs_wb = in_inc || in_dec;

  always_comb begin
    if (in_inc)      upd_word = word + ONE;
    else if (in_dec) upd_word = word - ONE;
    else             upd_word = word;
  end

endmodule

// File: rtl/ea_depth_limit.sv
module ea_depth_limit #(
  parameter int LW        = 8,
  parameter int LIM_RESET = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [LW-1:0] val,
  output logic [LW-1:0] limit
);

  logic [LW-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  lim_q <= LW'(LIM_RESET);
    else if (wr) lim_q <= val;
  end

  assign limit = lim_q;

endmodule

// File: rtl/ea_walk_fsm.sv
module ea_walk_fsm
  import eagen_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          start_ind,
  input  logic [LW-1:0] limit,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] upd_word,
  input  logic          needs_wb,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] wdata,
  output logic          req,
  output logic          we,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] ea,
  output logic          busy
);

  localparam logic [LW-1:0] CNT_ONE = {{(LW-1){1'b0}}, 1'b1};

  walk_state_e   st_q, st_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] wdat_q, wdat_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          cont_q, cont_d;
  logic [AW-1:0] ea_q, ea_d;
  logic          done_q, done_d;
  logic          err_q, err_d;

  logic          resolve;
  logic [AW-1:0] fin_addr;
  logic          fin_cont;
  logic [LW-1:0] fin_cnt;
  logic          walk_en;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    ptr_d    = ptr_q;
    wdat_d   = wdat_q;
    cnt_d    = cnt_q;
    cont_d   = cont_q;
    ea_d     = ea_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    resolve  = 1'b0;
    fin_addr = '0;
    fin_cont = 1'b0;
    fin_cnt  = cnt_q;

    unique case (st_q)
      WALK_IDLE: begin
        if (start) begin
          cnt_d = '0;
          if (start_ind) begin
            st_d  = WALK_READ;
            ptr_d = start_addr;
          end else begin
            done_d = 1'b1;
            ea_d   = start_addr;
          end
        end
      end
      WALK_READ: begin
        if (mem_ack) begin
          cont_d = mem_rdata[DW-1];
          if (needs_wb) begin
            wdat_d = upd_word;
            cnt_d  = cnt_q + CNT_ONE;
            st_d   = WALK_WRITE;
          end else begin
            resolve  = 1'b1;
            fin_addr = mem_rdata[AW-1:0];
            fin_cont = mem_rdata[DW-1];
            fin_cnt  = cnt_q + CNT_ONE;
          end
        end
      end
      WALK_WRITE: begin
        if (mem_ack) begin
          resolve  = 1'b1;
          fin_addr = wdat_q[AW-1:0];
          fin_cont = cont_q;
          fin_cnt  = cnt_q;
        end
      end
      default: st_d = WALK_IDLE;
    endcase

    if (resolve) begin
      cnt_d = fin_cnt;
      if (fin_cnt >= limit) begin
        err_d = 1'b1;
        st_d  = WALK_IDLE;
      end else if (fin_cont) begin
        ptr_d = fin_addr;
        st_d  = WALK_READ;
      end else begin
        done_d = 1'b1;
        ea_d   = fin_addr;
        st_d   = WALK_IDLE;
      end
    end
  end

  assign walk_en = start || (st_q != WALK_IDLE);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WALK_IDLE;
      ptr_q  <= '0;
      wdat_q <= '0;
      cnt_q  <= '0;
      cont_q <= 1'b0;
    end else if (walk_en) begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      wdat_q <= wdat_d;
      cnt_q  <= cnt_d;
      cont_q <= cont_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ea_q <= '0;
    else if (done_d) ea_q <= ea_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign ptr   = ptr_q;
  assign wdata = wdat_q;
  assign req   = (st_q == WALK_READ) || (st_q == WALK_WRITE);
  assign we    = (st_q == WALK_WRITE);
  assign done  = done_q;
  assign err   = err_q;
  assign ea    = ea_q;
  assign busy  = (st_q != WALK_IDLE);

endmodule

// File: rtl/ea_indirect_gen.sv
module ea_indirect_gen #(
  parameter int AW        = 15,
  parameter int DW        = 16,
  parameter int LW        = 8,
  parameter int LIM_RESET = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] instr,
  input  logic [AW-1:0] pc_next,
  input  logic [DW-1:0] acc2,
  input  logic [DW-1:0] acc3,
  input  logic          lim_wr,
  input  logic [LW-1:0] lim_val,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] ea
);

  logic          rst_meta_q;
  logic          rst_sync_n;
  logic [AW-1:0] start_addr;
  logic          start_ind;
  logic [LW-1:0] limit;
  logic [DW-1:0] upd_word;
  logic          needs_wb;
  logic          busy;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ea_base_calc #(.AW(AW), .DW(DW), .DISP_W(8)) u_base (
    .instr    (instr),
    .pc_next  (pc_next),
    .reg2     (acc2),
    .reg3     (acc3),
    .addr     (start_addr),
    .indirect (start_ind)
  );

  ea_depth_limit #(.LW(LW), .LIM_RESET(LIM_RESET)) u_lim (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr    (lim_wr),
    .val   (lim_val),
    .limit (limit)
  );

  ea_ptr_update #(.AW(AW), .DW(DW), .INC_LO(16), .DEC_LO(24), .SPAN(8)) u_upd (
    .loc      (mem_addr),
    .word     (mem_rdata),
    .upd_word (upd_word),
    .needs_wb (needs_wb)
  );

  ea_walk_fsm #(.AW(AW), .DW(DW), .LW(LW)) u_walk (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .start_addr (start_addr),
    .start_ind  (start_ind),
    .limit      (limit),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .upd_word   (upd_word),
    .needs_wb   (needs_wb),
    .ptr        (mem_addr),
    .wdata      (mem_wdata),
    .req        (mem_req),
    .we         (mem_we),
    .done       (done),
    .err        (err),
    .ea         (ea),
    .busy       (busy)
  );

endmodule

// File: rtl/ea_indirect_gen_chk.sv
module ea_indirect_gen_chk #(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          start_ind,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          done,
  input logic          err
);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_direct_next: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !start_ind) |=> (done && !mem_req));

  a_r10_no_both: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err);

  a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  a_r12_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  a_r12_quiet_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !mem_req);

  a_r7_write_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && (mem_addr >= AW'(16)) && (mem_addr <= AW'(31))));

  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mem_ack) |=> busy);

endmodule

bind ea_indirect_gen ea_indirect_gen_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .start_ind (start_ind),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .done      (done),
  .err       (err)
);

// File: tb/ea_indirect_gen_tb.sv
`timescale 1ns/1ps
module ea_indirect_gen_tb;

  localparam int MEMW = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [14:0] pc_next = '0;
  logic [15:0] acc2 = '0;
  logic [15:0] acc3 = '0;
  logic        lim_wr = 1'b0;
  logic [7:0]  lim_val = '0;
  logic        mem_req, mem_we, done, err;
  logic [14:0] mem_addr, ea;
  logic [15:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  ea_indirect_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_next(pc_next),
    .acc2(acc2), .acc3(acc3), .lim_wr(lim_wr), .lim_val(lim_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .err(err), .ea(ea)
  );

  always #4 clk = ~clk;

  logic [15:0] mem  [MEMW];
  logic [15:0] mmem [MEMW];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_ack_cyc = 0;
  int nreads = 0;
  int lim_model = 16;
  int dly = 0;
  bit finished = 0;
  logic        op_we;
  logic [14:0] op_addr;
  logic [15:0] op_wdata;

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: acknowledge after a random wait, commit after the ack edge
  always @(negedge clk) begin
    if (mem_ack) begin
      if (op_we) mem[op_addr[9:0]] = op_wdata;
      else       nreads = nreads + 1;
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (dly == 0) begin
        op_we        = mem_we;
        op_addr      = mem_addr;
        op_wdata     = mem_wdata;
        mem_rdata    = mem[mem_addr[9:0]];
        mem_ack      = 1'b1;
        last_ack_cyc = cyc;
        dly          = $urandom % 3;
      end else begin
        dly = dly - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic [15:0] mk(input bit ind, input [1:0] sel, input [7:0] d);
    mk = {5'b00101, ind, sel, d};
  endfunction

  task automatic model_walk(input [15:0] ins, input [14:0] pcv, input [15:0] a2v,
                            input [15:0] a3v, output [14:0] eav, output bit erv,
                            output int rd);
    logic [7:0]  d;
    logic [14:0] sx;
    logic [14:0] a;
    logic [15:0] w;
    bit          c;
    int          k;
    d  = ins[7:0];
    sx = {{7{d[7]}}, d};
    case (ins[9:8])
      2'd0:    a = {7'd0, d};
      2'd1:    a = pcv - 15'd1 + sx;
      2'd2:    a = a2v[14:0] + sx;
      default: a = a3v[14:0] + sx;
    endcase
    erv = 0;
    rd  = 0;
    k   = 0;
    if (ins[10]) begin
      for (int g = 0; g < 300; g++) begin
        w = mmem[a[9:0]];
        k++;
        rd++;
        c = w[15];
        if (a >= 15'd16 && a <= 15'd23) begin
          w = w + 16'd1; mmem[a[9:0]] = w;
        end else if (a >= 15'd24 && a <= 15'd31) begin
          w = w - 16'd1; mmem[a[9:0]] = w;
        end
        a = w[14:0];
        if (k >= lim_model) begin erv = 1; break; end
        if (!c) break;
      end
    end
    eav = a;
  endtask

  task automatic set_limit(input int v);
    @(negedge clk);
    lim_wr = 1'b1; lim_val = v[7:0];
    @(negedge clk);
    lim_wr = 1'b0;
    lim_model = v;
  endtask

  task automatic put(input int idx, input [15:0] w);
    mem[idx] = w;
    mmem[idx] = w;
  endtask

  task automatic build_chain(input int base, input int n);
    for (int i = 0; i < n; i++)
      put(base + i, (i < n - 1) ? (16'h8000 | 16'(base + i + 1)) : 16'h0200);
  endtask

  task automatic run_walk(input [15:0] ins, input [14:0] pcv, input [15:0] a2v,
                          input [15:0] a3v, input string tag);
    logic [14:0] e_ea;
    bit          e_err;
    int          e_rd;
    int          rd0;
    int          waited;
    bit          got_done, got_err;
    logic [14:0] got_ea;
    int          at_cyc;
    model_walk(ins, pcv, a2v, a3v, e_ea, e_err, e_rd);
    rd0 = nreads;
    @(negedge clk);
    instr = ins; pc_next = pcv; acc2 = a2v; acc3 = a3v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!(done || err) && waited < 500) begin
      @(negedge clk);
      waited++;
    end
    got_done = done; got_err = err; got_ea = ea; at_cyc = cyc;
    if (waited >= 500) begin
      chk(0, {tag, " R12 timeout"}, waited, 0);
    end else begin
      chk(got_err == e_err, {tag, " R10 err flag"}, got_err, e_err);
      chk(got_done == !e_err, {tag, " R6 done flag"}, got_done, !e_err);
      if (!e_err) chk(got_ea == e_ea, {tag, " R6 R3 R4 address"}, got_ea, e_ea);
      if (!ins[10]) chk(waited == 0, {tag, " R5 direct latency"}, waited, 0);
      else chk(at_cyc == last_ack_cyc + 1, {tag, " R12 result after last ack"},
               at_cyc - last_ack_cyc, 1);
    end
    @(negedge clk);
    chk(!done && !err, {tag, " R5 single pulse"}, {done, err}, 0);
    chk(nreads - rd0 == e_rd, {tag, " R10 read count"}, nreads - rd0, e_rd);
    for (int i = 16; i < 32; i++) begin
      if (mem[i] != mmem[i]) begin
        chk(0, {tag, " R7 R8 autoindex word"}, mem[i], mmem[i]);
        mmem[i] = mem[i];
      end
    end
  endtask

  // global watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s;
    int dones;
    logic [15:0] w;
    s = $urandom(32'h5eed);
    for (int i = 0; i < MEMW; i++) put(i, 16'h0000);
    repeat (3) @(negedge clk);
    chk(!done && !err && !mem_req, "R1 outputs in reset", {done, err, mem_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !err && !mem_req, "R1 outputs after reset", {done, err, mem_req}, 0);

    // R1/R10: default limit 16: 15 reads succeed, 16 reads fail
    build_chain(16'h100, 15);
    run_walk(mk(1, 2, 8'h00), 15'd1, 16'h0100, 16'h0, "R1 R10 chain15");
    build_chain(16'h100, 16);
    run_walk(mk(1, 2, 8'h00), 15'd1, 16'h0100, 16'h0, "R1 R10 chain16");

    // R2..R5 direct modes
    run_walk(mk(0, 0, 8'hFF), 15'h1234, 16'h0, 16'h0, "R2 page zero");
    run_walk(mk(0, 1, 8'h80), 15'h0005, 16'h0, 16'h0, "R3 pc wrap");
    run_walk(mk(0, 1, 8'h03), 15'h2000, 16'h0, 16'h0, "R3 pc fwd");
    run_walk(mk(0, 2, 8'h01), 15'h0, 16'hFFFF, 16'h0, "R4 acc2 wrap");
    run_walk(mk(0, 3, 8'hFE), 15'h0, 16'h0, 16'h1234, "R4 acc3 neg");

    // R6 single level
    put(16'h50, 16'h0123);
    run_walk(mk(1, 0, 8'h50), 15'h0, 16'h0, 16'h0, "R6 one level");
    // R7/R9 increment turns bit 15 on but the walk stops
    put(16, 16'h7FFF);
    run_walk(mk(1, 0, 8'd16), 15'h0, 16'h0, 16'h0, "R7 R9 inc");
    chk(mem[16] == 16'h8000, "R7 written value", mem[16], 16'h8000);
    // R8/R9 decrement clears bit 15 but the walk goes on
    put(24, 16'h8000);
    put(10'h3FF, 16'h0042);
    run_walk(mk(1, 0, 8'd24), 15'h0, 16'h0, 16'h0, "R8 R9 dec");
    chk(mem[24] == 16'h7FFF, "R8 written value", mem[24], 16'h7FFF);
    put(25, 16'h0000);
    run_walk(mk(1, 0, 8'd25), 15'h0, 16'h0, 16'h0, "R8 R9 dec wrap");

    // R10 programmed limit
    set_limit(3);
    build_chain(16'h180, 2);
    run_walk(mk(1, 2, 8'h00), 15'h0, 16'h0180, 16'h0, "R10 lim3 two");
    build_chain(16'h180, 3);
    run_walk(mk(1, 2, 8'h00), 15'h0, 16'h0180, 16'h0, "R10 lim3 three");
    set_limit(16);

    // R11 start during a walk
    build_chain(16'h140, 4);
    @(negedge clk);
    instr = mk(1, 2, 8'h00); acc2 = 16'h0140; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    instr = mk(0, 0, 8'h33); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin
        dones++;
        chk(ea == 15'h0200, "R11 address kept", ea, 15'h0200);
      end
      @(negedge clk);
    end
    chk(dones == 1, "R11 one result", dones, 1);

    // random mix
    for (int i = 0; i < MEMW; i++) begin
      w = 16'($urandom);
      if ($urandom % 4 != 0) w[15] = 1'b0;
      put(i, w);
    end
    for (int t = 0; t < 400; t++) begin
      logic [15:0] ri;
      if (t % 50 == 10) set_limit(1 + $urandom % 20);
      if (t % 50 == 30) set_limit(16);
      ri = mk($urandom % 2, 2'($urandom), 8'($urandom));
      if ($urandom % 4 == 0) ri = mk(1, 0, 8'(16 + $urandom % 16));
      run_walk(ri, 15'($urandom), 16'($urandom), 16'($urandom), "R6 R7 R8 R10 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule